// File: doc/BRIEF.md
# Polynomial Audio Tone Channel

One sound channel of a game-console sound generator. Software programs it through three write-only registers on a byte-wide address/data/write-strobe bus: a 4-bit tone selector, a 5-bit frequency divider and a 4-bit loudness value. A 30 kHz reference arrives as a one-cycle enable pulse (`ref_tick`) in the system clock domain. The channel divides that pulse train by the programmed frequency value plus one. Each divided tick is one "step" of a noise/tone generator built from a shared pre-divider and three maximal-length shift registers of 4, 5 and 9 bits.

The channel output is a 4-bit level. On every step it is reloaded with the loudness value when the newly produced tone bit is 1, and with zero when the tone bit is 0. Two instances with `CHAN_SEL` set to 0 and 1 share one bus. Each instance decodes its own address of each register pair. The analog output stage and the mixing of channels stay outside this block.

Top module: `poly_tone_channel`

## Requirements
- R1: After reset, `level` is 0, the selector, frequency and loudness registers are 0, and all three shift registers hold all-ones.
- R2: With `CHAN_SEL`=0, a write to address 0 sets the selector from data bits 3:0, address 2 sets the frequency from bits 4:0, and address 4 sets the loudness from bits 3:0. Upper data bits are ignored. A write to any other address (1, 3, 5, 6, 7) changes nothing visible at `level`.
- R3: With frequency value F, a step occurs on every (F+1)-th `ref_tick`, giving divisors 1 to 32. Writing a new F does not clear the divider count: if the count already reached the new F, the next `ref_tick` is a step.
- R4: On each step, `level` becomes the loudness value if the new tone bit is 1, or 0 otherwise. Loudness 0 is silent and 15 is the largest level.
- R5: Selector values 0 and 11 hold the tone bit at 1, so every step shows the loudness value.
- R6: Selector values 4 and 5 produce a square wave with a period of 2 steps (1 high).
- R7: Selector values 12 and 13 give a period of 6 steps (3 high). Values 6 and 10 give a period of 31 steps (15 high). Value 14 gives a period of 93 steps (46 high).
- R8: The 4-bit register shifts toward its MSB, with feedback bit3 XOR bit2. The tone bit is its MSB. Selector 1 clocks it every step (period 15, 8 high). Selector 2 clocks it every 15th step (period 225, 120 high).
- R9: The 5-bit register has feedback bit4 XOR bit2, and the tone bit is its MSB. It is clocked every step for selector 9 (period 31, 16 high), every 2nd step for selector 7 (period 62, 32 high), and every 6th step for selector 15 (period 186, 96 high).
- R10: Selector 8 clocks the 9-bit register, with feedback bit8 XOR bit4, every step. The tone is its MSB, with a period of 511 steps and 256 high.
- R11: Selector 3 clocks the 5-bit register every step. On steps where the 5-bit MSB is 1, it also clocks the 4-bit register. The tone is the 4-bit MSB, and the pattern repeats every 465 steps without being constant.
- R12: `level` changes only on steps. A register write alone never changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle 30 kHz reference pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address within the window |
| wr_data | input | DATA_W | Write data |
| level | output | VOL_W | Gated loudness output |

## Verification
The bench uses the defaults: `CHAN_SEL`=0, a 5-bit frequency field and a 7-bit pre-divider. With these values the full divisor range of 1 to 32 and the longest 511-step noise pattern can be reached within a few thousand steps. Running frequency 0 lets every reference tick become a step. The bench can then record two full periods of every selector and test exact period, high count and minimality. The odd addresses belong to the sibling channel, which lets the bench confirm that writes there leave the output alone.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int PRE_W = 7;

  typedef enum logic [2:0] {
    SRC_ONE  = 3'd0,
    SRC_PURE = 3'd1,
    SRC_P4   = 3'd2,
    SRC_P5   = 3'd3,
    SRC_P9   = 3'd4
  } tone_src_e;

  typedef struct packed {
    tone_src_e        src;
    logic [PRE_W-1:0] prescale;
    logic             adv_p4;
    logic             adv_p5;
    logic             adv_p9;
    logic             gate_p4;
  } mode_cfg_t;

  function automatic mode_cfg_t decode_mode(input logic [3:0] sel);
    mode_cfg_t c;
    c.src      = SRC_ONE;
    c.prescale = PRE_W'(1);
    c.adv_p4   = 1'b0;
    c.adv_p5   = 1'b0;
    c.adv_p9   = 1'b0;
    c.gate_p4  = 1'b0;
    case (sel)
      4'd1:         begin c.src = SRC_P4; c.adv_p4 = 1'b1; end
      4'd2:         begin c.src = SRC_P4; c.adv_p4 = 1'b1; c.prescale = PRE_W'(15); end
      4'd3:         begin c.src = SRC_P4; c.adv_p4 = 1'b1; c.adv_p5 = 1'b1; c.gate_p4 = 1'b1; end
      4'd4, 4'd5:   begin c.src = SRC_PURE; c.prescale = PRE_W'(2); end
      4'd6, 4'd10:  begin c.src = SRC_PURE; c.prescale = PRE_W'(31); end
      4'd7:         begin c.src = SRC_P5; c.adv_p5 = 1'b1; c.prescale = PRE_W'(2); end
      4'd8:         begin c.src = SRC_P9; c.adv_p9 = 1'b1; end
      4'd9:         begin c.src = SRC_P5; c.adv_p5 = 1'b1; end
      4'd12, 4'd13: begin c.src = SRC_PURE; c.prescale = PRE_W'(6); end
      4'd14:        begin c.src = SRC_PURE; c.prescale = PRE_W'(93); end
      4'd15:        begin c.src = SRC_P5; c.adv_p5 = 1'b1; c.prescale = PRE_W'(6); end
      default:      c.src = SRC_ONE;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/ptc_regs.sv
module ptc_regs #(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8,
  parameter int CHAN_SEL = 0,
  parameter int SEL_W    = 4,
  parameter int FREQ_W   = 5,
  parameter int VOL_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [SEL_W-1:0]  sel_q,
  output logic [FREQ_W-1:0] freq_q,
  output logic [VOL_W-1:0]  vol_q
);
  localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(0 + CHAN_SEL);
  localparam logic [ADDR_W-1:0] A_FREQ = ADDR_W'(2 + CHAN_SEL);
  localparam logic [ADDR_W-1:0] A_VOL  = ADDR_W'(4 + CHAN_SEL);

  logic [SEL_W-1:0]  sel_d;
  logic [FREQ_W-1:0] freq_d;
  logic [VOL_W-1:0]  vol_d;
  logic              hit_sel, hit_freq, hit_vol;

  assign hit_sel  = wr_en && (wr_addr == A_SEL);
  assign hit_freq = wr_en && (wr_addr == A_FREQ);
  assign hit_vol  = wr_en && (wr_addr == A_VOL);

  always_comb begin
    sel_d  = hit_sel  ? wr_data[SEL_W-1:0]  : sel_q;
    freq_d = hit_freq ? wr_data[FREQ_W-1:0] : freq_q;
    vol_d  = hit_vol  ? wr_data[VOL_W-1:0]  : vol_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      freq_q <= '0;
      vol_q  <= '0;
    end else begin
      sel_q  <= sel_d;
      freq_q <= freq_d;
      vol_q  <= vol_d;
    end
  end

  p_foreign_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || (wr_addr != A_SEL && wr_addr != A_FREQ && wr_addr != A_VOL))
      |=> ($stable(sel_q) && $stable(freq_q) && $stable(vol_q)));
endmodule

// File: rtl/ptc_freq_div.sv
module ptc_freq_div #(
  parameter int FREQ_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic [FREQ_W-1:0] freq,
  output logic              step
);
  logic [FREQ_W-1:0] cnt_q, cnt_d;
  logic              reached;

  assign reached = (cnt_q >= freq);
  assign step    = ref_tick && reached;

  always_comb begin
    cnt_d = cnt_q;
    if (ref_tick) cnt_d = reached ? '0 : cnt_q + FREQ_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_step_needs_ref_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> ref_tick);
  p_count_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_tick |=> $stable(cnt_q));
  p_count_restarts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cnt_q == '0));
endmodule

// File: rtl/ptc_lfsr.sv
module ptc_lfsr #(
  parameter int W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic msb_now,
  output logic msb_nxt
);
  logic [W-1:0] q, d;
  logic         fb;

  generate
    if (W == 9) begin : g_tap9
      assign fb = q[8] ^ q[4];
    end else if (W == 5) begin : g_tap5
      assign fb = q[4] ^ q[2];
    end else begin : g_tap4
      assign fb = q[W-1] ^ q[W-2];
    end
  endgenerate

  always_comb begin
    d = q;
    if (adv) d = {q[W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '1;
    else        q <= d;
  end

  assign msb_now = q[W-1];
  assign msb_nxt = d[W-1];

  p_never_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    q != '0);
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(q));
endmodule

// File: rtl/ptc_tone_gen.sv
module ptc_tone_gen
  import ptc_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [SEL_W-1:0] sel,
  output logic             tone_nxt
);
  mode_cfg_t        cfg;
  logic [PRE_W-1:0] pd_q, pd_d;
  logic             pd_wrap, slow;
  logic             p4_now, p4_nxt, p5_now, p5_nxt, p9_now, p9_nxt;
  logic             adv4, adv5, adv9;
  logic             p4_unused, p9_unused;

  assign cfg     = decode_mode(sel[3:0]);
  assign pd_wrap = (pd_q >= cfg.prescale - PRE_W'(1));
  assign slow    = step && pd_wrap;

  always_comb begin
    pd_d = pd_q;
    if (step) pd_d = pd_wrap ? '0 : pd_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pd_q <= '0;
    else        pd_q <= pd_d;
  end

  assign adv5 = slow && cfg.adv_p5;
  assign adv9 = slow && cfg.adv_p9;
  assign adv4 = slow && cfg.adv_p4 && (!cfg.gate_p4 || p5_now);

  ptc_lfsr #(.W(4)) u_p4 (.clk(clk), .rst_n(rst_n), .adv(adv4), .msb_now(p4_now), .msb_nxt(p4_nxt));
  ptc_lfsr #(.W(5)) u_p5 (.clk(clk), .rst_n(rst_n), .adv(adv5), .msb_now(p5_now), .msb_nxt(p5_nxt));
  ptc_lfsr #(.W(9)) u_p9 (.clk(clk), .rst_n(rst_n), .adv(adv9), .msb_now(p9_now), .msb_nxt(p9_nxt));

  assign p4_unused = p4_now;
  assign p9_unused = p9_now;

  always_comb begin
    case (cfg.src)
      SRC_PURE: tone_nxt = (pd_d < (cfg.prescale >> 1));
      SRC_P4:   tone_nxt = p4_nxt;
      SRC_P5:   tone_nxt = p5_nxt;
      SRC_P9:   tone_nxt = p9_nxt;
      default:  tone_nxt = 1'b1;
    endcase
  end

  p_pd_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (pd_q < $past(cfg.prescale)));
  p_pd_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pd_q));
endmodule

// File: rtl/poly_tone_channel.sv
module poly_tone_channel #(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8,
  parameter int CHAN_SEL = 0,
  parameter int FREQ_W   = 5,
  parameter int VOL_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [VOL_W-1:0]  level
);
  localparam int SEL_W = 4;

  logic              rst_meta, rst_sync;
  logic [SEL_W-1:0]  sel;
  logic [FREQ_W-1:0] freq;
  logic [VOL_W-1:0]  vol;
  logic              step, tone_nxt;
  logic [VOL_W-1:0]  level_q, level_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  ptc_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAN_SEL(CHAN_SEL),
    .SEL_W(SEL_W), .FREQ_W(FREQ_W), .VOL_W(VOL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sel_q(sel), .freq_q(freq), .vol_q(vol)
  );

  ptc_freq_div #(.FREQ_W(FREQ_W)) u_div (
    .clk(clk), .rst_n(rst_sync), .ref_tick(ref_tick), .freq(freq), .step(step)
  );

  ptc_tone_gen #(.SEL_W(SEL_W)) u_tone (
    .clk(clk), .rst_n(rst_sync), .step(step), .sel(sel), .tone_nxt(tone_nxt)
  );

  always_comb begin
    level_d = level_q;
    if (step) level_d = tone_nxt ? vol : '0;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) level_q <= '0;
    else           level_q <= level_d;
  end

  assign level = level_q;

  p_level_hold_r12: assert property (@(posedge clk) disable iff (!rst_sync)
    !step |=> $stable(level_q));
  p_level_values_r4: assert property (@(posedge clk) disable iff (!rst_sync)
    step |=> (level_q == $past(vol) || level_q == '0));
endmodule

// File: tb/poly_tone_channel_test.sv
module poly_tone_channel_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] level;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  poly_tone_channel uut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .level(level)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); ref_tick = 1'b1;
    @(negedge clk); ref_tick = 1'b0;
  endtask

  task automatic ticks_to_change(output int n);
    logic [3:0] prev;
    prev = level; n = 0;
    do begin tick(); n++; end while (level == prev && n < 100);
  endtask

  task automatic t_reset();
    chk(level == 4'd0, "R1", "level after reset", level, 0);
    wr(3'd4, 8'd7); tick();
    chk(level == 4'd7, "R1", "default selector holds tone high", level, 7);
  endtask

  task automatic t_volume();
    wr(3'd0, 8'd0); wr(3'd2, 8'd0); wr(3'd4, 8'd12);
    chk(level == 4'd7, "R12", "level before step", level, 7);
    tick();
    chk(level == 4'd12, "R4", "loudness 12", level, 12);
    wr(3'd4, 8'd0);
    chk(level == 4'd12, "R12", "write alone keeps level", level, 12);
    tick();
    chk(level == 4'd0, "R4", "loudness 0 silent", level, 0);
    wr(3'd4, 8'd15); tick();
    chk(level == 4'd15, "R4", "loudness 15", level, 15);
  endtask

  task automatic t_const();
    bit ok;
    wr(3'd0, 8'd11); wr(3'd4, 8'd5);
    ok = 1'b1;
    for (int i = 0; i < 8; i++) begin tick(); if (level != 4'd5) ok = 1'b0; end
    chk(ok, "R5", "selector 11 constant", level, 5);
    wr(3'd0, 8'd0);
    ok = 1'b1;
    for (int i = 0; i < 8; i++) begin tick(); if (level != 4'd5) ok = 1'b0; end
    chk(ok, "R5", "selector 0 constant", level, 5);
  endtask

  task automatic t_decode();
    wr(3'd4, 8'hF6); tick();
    chk(level == 4'd6, "R2", "upper data bits ignored", level, 6);
    wr(3'd5, 8'd3); wr(3'd1, 8'd4); wr(3'd3, 8'd31); wr(3'd7, 8'hFF); wr(3'd6, 8'h00);
    tick();
    chk(level == 4'd6, "R2", "foreign writes, step 1", level, 6);
    tick();
    chk(level == 4'd6, "R2", "foreign writes, step 2", level, 6);
  endtask

  task automatic t_freq(input int f);
    int n;
    wr(3'd0, 8'd4); wr(3'd2, 8'(f)); wr(3'd4, 8'd9);
    ticks_to_change(n);
    ticks_to_change(n);
    chk(n == f + 1, "R3", "ticks per step", n, f + 1);
    ticks_to_change(n);
    chk(n == f + 1, "R3", "ticks per step again", n, f + 1);
  endtask

  task automatic t_phase();
    int n;
    logic [3:0] prev;
    wr(3'd0, 8'd4); wr(3'd4, 8'd9); wr(3'd2, 8'd31);
    ticks_to_change(n); ticks_to_change(n);
    repeat (10) tick();
    prev = level;
    wr(3'd2, 8'd11);
    tick();
    chk(level == prev, "R3", "no step one tick after raise", level, prev);
    tick();
    chk(level != prev, "R3", "step two ticks after raise", level, 9 - prev);
    wr(3'd2, 8'd31);
    ticks_to_change(n);
    repeat (10) tick();
    prev = level;
    wr(3'd2, 8'd3);
    tick();
    chk(level != prev, "R3", "immediate step after lowering", level, 9 - prev);
  endtask

  task automatic t_seq(input logic [3:0] mode, input int n, input int ones,
                       input bit minchk, input string req);
    logic s [0:1023];
    int   cnt;
    bit   ok;
    wr(3'd0, 8'(mode)); wr(3'd2, 8'd0); wr(3'd4, 8'd7);
    repeat (120) tick();
    ok = 1'b1;
    for (int i = 0; i < 2 * n; i++) begin
      tick();
      s[i] = (level == 4'd7);
      if (level != 4'd7 && level != 4'd0) ok = 1'b0;
    end
    chk(ok, req, $sformatf("selector %0d only 0 or loudness", mode), level, 7);
    ok = 1'b1;
    for (int i = 0; i < n; i++) if (s[i] != s[i + n]) ok = 1'b0;
    chk(ok, req, $sformatf("selector %0d repeats after %0d", mode, n), 0, 1);
    cnt = 0;
    for (int i = 0; i < n; i++) if (s[i]) cnt++;
    if (ones >= 0) chk(cnt == ones, req, $sformatf("selector %0d high count", mode), cnt, ones);
    else           chk(cnt > 0 && cnt < n, req, $sformatf("selector %0d not constant", mode), cnt, n / 2);
    if (minchk) begin
      for (int d = 1; d < n; d++) begin
        if (n % d == 0) begin
          ok = 1'b1;
          for (int i = 0; i < n; i++) if (s[i] != s[i + d]) ok = 1'b0;
          chk(!ok, req, $sformatf("selector %0d shorter period", mode), d, n);
        end
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_volume();
    t_const();
    t_decode();
    t_freq(0); t_freq(3); t_freq(31);
    t_phase();
    t_seq(4'd4, 2, 1, 1'b1, "R6");
    t_seq(4'd5, 2, 1, 1'b1, "R6");
    t_seq(4'd12, 6, 3, 1'b1, "R7");
    t_seq(4'd13, 6, 3, 1'b1, "R7");
    t_seq(4'd6, 31, 15, 1'b1, "R7");
    t_seq(4'd10, 31, 15, 1'b1, "R7");
    t_seq(4'd14, 93, 46, 1'b1, "R7");
    t_seq(4'd1, 15, 8, 1'b1, "R8");
    t_seq(4'd2, 225, 120, 1'b1, "R8");
    t_seq(4'd9, 31, 16, 1'b1, "R9");
    t_seq(4'd7, 62, 32, 1'b1, "R9");
    t_seq(4'd15, 186, 96, 1'b1, "R9");
    t_seq(4'd8, 511, 256, 1'b1, "R10");
    t_seq(4'd3, 465, -1, 1'b0, "R11");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule